// File: doc/BRIEF.md
# Frame Clock Generator with Slip Correction

This block derives all frame-level timing of a base-station radio controller from one master clock, nominally 13.824 MHz. It produces a codec bit clock, nominally one quarter of the master rate (3.456 MHz). It also produces a 1200 Hz square wave for switching between two synthesizers, a one-cycle frame-start marker at 100 Hz, and a clock-enable pulse train for an external microcontroller. The rate of that pulse train is selectable from the full master rate down to one sixty-fourth of it. A reference-clock enable for the synthesizer is gated off while the synthesizer is powered down.

The frame timing can follow an outside reference. In slave mode it follows a 100 Hz sync from another base station. In highway mode it follows the 8 kHz framing of a digital highway. In free-run mode it relies on the crystal alone. When the local counter drifts from the reference by more than one codec period, a single codec period is stretched to five master cycles or shortened to three. Each reference event causes at most one such change. In free-run and highway modes the block acts as the timing master and copies its frame marker onto a sync output. In slave mode that output stays low.

One frame holds `FRAME_TICKS` codec periods, 34560 by default. The 8 kHz sub-frame holds `FRAME_TICKS/HWY_PER_FRAME` periods, 432 by default.

Top module: `frame_clock_gen`

## Requirements
- R1: After reset is released, the frame marker is high in the first cycle, the codec clock is high, and the 1200 Hz output is low.
- R2: Without corrections, each codec period is 4 master cycles: 2 high, then 2 low. A frame is `FRAME_TICKS` codec periods, which is 4*`FRAME_TICKS` master cycles.
- R3: The frame marker is a one-cycle pulse at the start of codec period zero of each frame. The sync output carries the same pulse when the mode is free-run (`mode_i`=0) or highway (`mode_i`=1), and stays low in slave mode (`mode_i`=2).
- R4: The 1200 Hz output toggles every `FRAME_TICKS`/24 codec periods. This gives 12 full periods per frame, and the output is low at frame start.
- R5: For `mcu_sel_i` = s with s in 0..6, `mcu_ce_o` is high in exactly one of every 2^s cycles. A value of 7 acts like 6.
- R6: `synth_ref_en_o` is high exactly when `synth_pd_i` is low.
- R7: In slave mode, a rising edge on `ext_sync_i` is sampled through a two-stage synchronizer. If the frame's codec-period count v at that time is in 2 .. `FRAME_TICKS`/2-1, the next codec period is 5 master cycles long, so the frame lengthens by one cycle.
- R8: In slave mode, a count v in `FRAME_TICKS`/2 .. `FRAME_TICKS`-2 makes the next codec period 3 master cycles long, so the frame shortens by one cycle.
- R9: In slave mode, a count v of 0, 1 or `FRAME_TICKS`-1 counts as locked and makes no change.
- R10: In highway mode, the R7 to R9 rule applies to rising edges of `hwy_sync_i`. The rule uses the count modulo the sub-frame length H=`FRAME_TICKS`/`HWY_PER_FRAME`, with bounds 2, H/2 and H-2 instead.
- R11: Every codec period lasts 3, 4 or 5 master cycles. One reference event changes at most one period.
- R12: Free-run mode ignores both sync inputs. Slave mode ignores `hwy_sync_i`, and highway mode ignores `ext_sync_i`.
- R13: A slave-mode reference whose period is 4*`FRAME_TICKS`±1 master cycles is tracked. Over 30 reference periods, 29 to 31 frame markers appear, and each frame lasts 4*`FRAME_TICKS`±1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 free-run, 1 highway lock, 2 slave lock, 3 as free-run |
| ext_sync_i | input | 1 | External 100 Hz sync from a master station |
| hwy_sync_i | input | 1 | Incoming 8 kHz highway framing |
| mcu_sel_i | input | 3 | Microcontroller clock divide exponent |
| synth_pd_i | input | 1 | Synthesizer power-down request |
| codec_clk_o | output | 1 | Codec bit clock |
| sw1200_o | output | 1 | 1200 Hz dual-synthesizer switching signal |
| frame_start_o | output | 1 | One-cycle frame-start marker |
| sync_out_o | output | 1 | 100 Hz sync output when master |
| mcu_ce_o | output | 1 | Microcontroller clock enable pulse |
| synth_ref_en_o | output | 1 | Synthesizer reference enable |

## Verification
A phase counter that gets stuck, or a correction that is applied twice, shows up in the frame-marker spacing within one frame. Each mistake moves that spacing by whole master cycles away from 4*`FRAME_TICKS`±1. A wrong decision window around the deadband or the half-way boundary shows up as a frame one cycle too long or too short, in the same frame as the reference edge. The bench places single reference edges in the middle of chosen codec periods so that synchronizer latency cannot move them across a boundary. A wrong mode gate shows up as a changed frame length, or as sync pulses where none are due.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  typedef enum logic [1:0] {
    CORR_NONE    = 2'd0,
    CORR_STRETCH = 2'd1,
    CORR_SHRINK  = 2'd2
  } corr_e;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_HWY   = 2'd1,
    MODE_SLAVE = 2'd2,
    MODE_SPARE = 2'd3
  } mode_e;

  // Phase decision: v is the count seen at the reference edge, span the cycle length.
  function automatic corr_e phase_decide(input int unsigned v, input int unsigned span);
    if (v <= 1 || v + 1 >= span) return CORR_NONE;
    else if (v < span / 2)       return CORR_STRETCH;
    else                         return CORR_SHRINK;
  endfunction

  function automatic int unsigned period_len(input corr_e c, input int unsigned nom);
    case (c)
      CORR_STRETCH: return nom + 1;
      CORR_SHRINK:  return nom - 1;
      default:      return nom;
    endcase
  endfunction

endpackage

// File: rtl/fcg_edge_sync.sv
module fcg_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], d_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/fcg_codec_div.sv
module fcg_codec_div
  import fcg_pkg::*;
#(
  parameter int unsigned DIV_NOM = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  evt_i,
  input  corr_e evt_corr_i,
  output logic  period_start_o,
  output logic  period_end_o,
  output logic  codec_clk_o
);
  localparam int unsigned PH_W = $clog2(DIV_NOM + 2);

  logic [PH_W-1:0] phase, cur_len;
  corr_e           pend, take;

  assign take           = evt_i ? evt_corr_i : pend;
  assign period_start_o = (phase == '0);
  assign period_end_o   = (phase == cur_len - PH_W'(1));
  assign codec_clk_o    = (phase < PH_W'(DIV_NOM / 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= '0;
      cur_len <= PH_W'(DIV_NOM);
      pend    <= CORR_NONE;
    end else if (period_end_o) begin
      phase   <= '0;
      cur_len <= PH_W'(period_len(take, DIV_NOM));
      pend    <= CORR_NONE;
    end else begin
      phase <= phase + PH_W'(1);
      if (evt_i) pend <= evt_corr_i;
    end
  end
endmodule

// File: rtl/fcg_frame_timer.sv
module fcg_frame_timer #(
  parameter int unsigned FRAME_TICKS   = 34560,
  parameter int unsigned HWY_PER_FRAME = 80,
  parameter int unsigned SW_TOGGLES    = 24,
  localparam int unsigned HWY_TICKS = FRAME_TICKS / HWY_PER_FRAME,
  localparam int unsigned SEG_TICKS = FRAME_TICKS / SW_TOGGLES,
  localparam int unsigned FC_W      = $clog2(FRAME_TICKS + 1),
  localparam int unsigned SC_W      = $clog2(HWY_TICKS + 1),
  localparam int unsigned GC_W      = $clog2(SEG_TICKS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            period_start_i,
  input  logic            period_end_i,
  output logic [FC_W-1:0] frame_cnt_o,
  output logic [SC_W-1:0] sub_cnt_o,
  output logic            sw_o,
  output logic            frame_start_o
);
  logic [GC_W-1:0] seg_cnt;
  logic            frame_wrap, sub_wrap, seg_wrap;

  assign frame_wrap    = (frame_cnt_o == FC_W'(FRAME_TICKS - 1));
  assign sub_wrap      = (sub_cnt_o == SC_W'(HWY_TICKS - 1));
  assign seg_wrap      = (seg_cnt == GC_W'(SEG_TICKS - 1));
  assign frame_start_o = period_start_i && (frame_cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_cnt_o <= '0;
      sub_cnt_o   <= '0;
      seg_cnt     <= '0;
      sw_o        <= 1'b0;
    end else if (period_end_i) begin
      frame_cnt_o <= frame_wrap ? '0 : frame_cnt_o + FC_W'(1);
      sub_cnt_o   <= (frame_wrap || sub_wrap) ? '0 : sub_cnt_o + SC_W'(1);
      seg_cnt     <= (frame_wrap || seg_wrap) ? '0 : seg_cnt + GC_W'(1);
      if (frame_wrap)    sw_o <= 1'b0;
      else if (seg_wrap) sw_o <= ~sw_o;
    end
  end
endmodule

// File: rtl/fcg_mcu_clk.sv
module fcg_mcu_clk #(
  parameter int unsigned MAX_SHIFT = 6,
  localparam int unsigned SEL_W = $clog2(MAX_SHIFT + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ce_o
);
  logic [MAX_SHIFT-1:0] cnt, mask;
  logic [SEL_W-1:0]     shift;

  assign shift = (sel_i > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel_i;

  always_comb begin
    for (int i = 0; i < MAX_SHIFT; i++) mask[i] = (SEL_W'(i) < shift);
  end

  assign ce_o = ((cnt & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else         cnt <= cnt + MAX_SHIFT'(1);
  end
endmodule

// File: rtl/frame_clock_gen.sv
module frame_clock_gen
  import fcg_pkg::*;
#(
  parameter int unsigned FRAME_TICKS   = 34560,
  parameter int unsigned HWY_PER_FRAME = 80,
  parameter int unsigned SW_TOGGLES    = 24,
  parameter int unsigned CODEC_DIV     = 4,
  parameter int unsigned MCU_MAX_SHIFT = 6,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       ext_sync_i,
  input  logic       hwy_sync_i,
  input  logic [2:0] mcu_sel_i,
  input  logic       synth_pd_i,
  output logic       codec_clk_o,
  output logic       sw1200_o,
  output logic       frame_start_o,
  output logic       sync_out_o,
  output logic       mcu_ce_o,
  output logic       synth_ref_en_o
);
  localparam int unsigned HWY_TICKS = FRAME_TICKS / HWY_PER_FRAME;
  localparam int unsigned FC_W      = $clog2(FRAME_TICKS + 1);
  localparam int unsigned SC_W      = $clog2(HWY_TICKS + 1);

  mode_e           mode;
  logic            ext_rise, hwy_rise;
  logic            period_start, period_end;
  logic            ref_evt;
  corr_e           corr_req;
  logic [FC_W-1:0] frame_cnt;
  logic [SC_W-1:0] sub_cnt;
  logic            is_master;

  assign mode      = mode_e'(mode_i);
  assign is_master = (mode != MODE_SLAVE);

  fcg_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_sync_i), .rise_o(ext_rise));
  fcg_edge_sync #(.STAGES(SYNC_STAGES)) u_hwy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hwy_sync_i), .rise_o(hwy_rise));

  always_comb begin
    ref_evt  = 1'b0;
    corr_req = CORR_NONE;
    case (mode)
      MODE_SLAVE: begin
        ref_evt  = ext_rise;
        corr_req = phase_decide(32'(frame_cnt), FRAME_TICKS);
      end
      MODE_HWY: begin
        ref_evt  = hwy_rise;
        corr_req = phase_decide(32'(sub_cnt), HWY_TICKS);
      end
      default: ;
    endcase
  end

  fcg_codec_div #(.DIV_NOM(CODEC_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(ref_evt), .evt_corr_i(corr_req),
    .period_start_o(period_start), .period_end_o(period_end),
    .codec_clk_o(codec_clk_o));

  fcg_frame_timer #(
    .FRAME_TICKS(FRAME_TICKS), .HWY_PER_FRAME(HWY_PER_FRAME), .SW_TOGGLES(SW_TOGGLES)
  ) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_start_i(period_start),
    .period_end_i(period_end), .frame_cnt_o(frame_cnt), .sub_cnt_o(sub_cnt),
    .sw_o(sw1200_o), .frame_start_o(frame_start_o));

  fcg_mcu_clk #(.MAX_SHIFT(MCU_MAX_SHIFT)) u_mcu (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(mcu_sel_i), .ce_o(mcu_ce_o));

  assign sync_out_o     = frame_start_o && is_master;
  assign synth_ref_en_o = ~synth_pd_i;
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic [2:0] mcu_sel_i,
  input logic       period_start,
  input logic       codec_clk_o,
  input logic       sw1200_o,
  input logic       frame_start_o,
  input logic       sync_out_o,
  input logic       mcu_ce_o
);
  logic [3:0] gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap <= '0;
    else if (period_start) gap <= 4'd1;
    else if (gap != 4'hF)  gap <= gap + 4'd1;
  end

  a_r11_period_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start |-> (gap == 4'd0 || (gap >= 4'd3 && gap <= 4'd5)));

  a_r2_codec_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start |-> codec_clk_o);

  a_r4_sw_low_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !sw1200_o);

  a_r3_sync_follows_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_out_o |-> frame_start_o);

  a_r3_slave_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |-> !sync_out_o);

  a_r3_marker_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  a_r5_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcu_sel_i == 3'd0) |-> mcu_ce_o);
endmodule

bind frame_clock_gen fcg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .mcu_sel_i(mcu_sel_i),
  .period_start(period_start), .codec_clk_o(codec_clk_o), .sw1200_o(sw1200_o),
  .frame_start_o(frame_start_o), .sync_out_o(sync_out_o), .mcu_ce_o(mcu_ce_o));

// File: tb/sim_frame_clock_gen.sv
module sim_frame_clock_gen;
  localparam int F  = 48;
  localparam int HP = 4;
  localparam int H  = F / HP;
  localparam int NF = 4 * F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic ext = 1'b0, hwy = 1'b0, pd = 1'b0;
  logic [2:0] sel = 3'd0;
  logic codec, sw, fs, so, ce, ren;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  frame_clock_gen #(.FRAME_TICKS(F), .HWY_PER_FRAME(HP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ext_sync_i(ext), .hwy_sync_i(hwy),
    .mcu_sel_i(sel), .synth_pd_i(pd), .codec_clk_o(codec), .sw1200_o(sw),
    .frame_start_o(fs), .sync_out_o(so), .mcu_ce_o(ce), .synth_ref_en_o(ren));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wait_marker();
    do @(negedge clk); while (!fs);
  endtask

  task automatic next_len(output int len);
    len = 0;
    do begin @(negedge clk); len++; end while (!fs);
  endtask

  // Pulse one sync input in codec period v of the current frame; return frame length.
  task automatic shot(input bit use_hwy, input int v, input int exp, input string req);
    int len;
    wait_marker();
    repeat (4 * v) @(negedge clk);
    if (use_hwy) hwy = 1'b1; else ext = 1'b1;
    len = 4 * v;
    do begin
      @(negedge clk); len++;
      if (len == 4 * v + 3) begin hwy = 1'b0; ext = 1'b0; end
    end while (!fs);
    check_eq(req, len, exp);
  endtask

  task automatic lock_run(input int period, input string req);
    int markers = 0, last = 0;
    wait_marker();
    fork
      begin
        for (int i = 0; i < 30; i++) begin
          ext = 1'b1; repeat (3) @(negedge clk);
          ext = 1'b0; repeat (period - 3) @(negedge clk);
        end
      end
      begin
        for (int c = 1; c <= 30 * period; c++) begin
          @(negedge clk);
          if (fs) begin
            markers++;
            check((c - last) >= NF - 1 && (c - last) <= NF + 1, req, c - last, NF);
            last = c;
          end
        end
      end
    join
    check(markers >= 29 && markers <= 31, req, markers, 30);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int len, n, hi, rises;
    logic prev;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_eq("R1 marker", int'(fs), 1);
    check_eq("R1 codec", int'(codec), 1);
    check_eq("R1 sw1200", int'(sw), 0);
    check_eq("R3 sync master", int'(so), 1);
    // R2 first frame length and codec waveform
    next_len(len);
    check_eq("R2 frame len", len, NF);
    rises = 0; hi = 0; prev = 1'b0; n = 0;
    for (int c = 0; c < NF; c++) begin
      if (codec && !prev) rises++;
      if (codec) hi++;
      if (sw && c > 0 && !prev) ; // placeholder-free: sw counted below
      prev = codec;
      @(negedge clk);
    end
    check_eq("R2 codec periods", rises, F);
    check_eq("R2 codec high cycles", hi, NF / 2);
    // R4 1200 Hz periods per frame, R3 sync pulses in master mode
    wait_marker();
    rises = 0; prev = 1'b0; n = 0;
    for (int c = 0; c < NF; c++) begin
      if (sw && !prev) rises++;
      if (so) n++;
      prev = sw;
      @(negedge clk);
    end
    check_eq("R4 sw periods", rises, 12);
    check_eq("R3 sync pulses free", n, 1);
    // R5 microcontroller enable sweep
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      n = 0;
      for (int c = 0; c < 64; c++) begin @(negedge clk); if (ce) n++; end
      check_eq("R5 ce count", n, 64 >> ((s > 6) ? 6 : s));
    end
    // R6 synth reference gate
    pd = 1'b1; #1 check_eq("R6 ref off", int'(ren), 0);
    pd = 1'b0; #1 check_eq("R6 ref on", int'(ren), 1);
    // R12 free mode ignores both
    shot(1'b0, 10, NF, "R12 free ext");
    shot(1'b1, 3, NF, "R12 free hwy");
    // slave mode
    mode = 2'd2;
    wait_marker();
    shot(1'b0, 2, NF + 1, "R7 stretch low");
    shot(1'b0, F / 2 - 1, NF + 1, "R7 stretch edge");
    shot(1'b0, F / 2, NF - 1, "R8 shrink edge");
    shot(1'b0, F - 2, NF - 1, "R8 shrink high");
    shot(1'b0, 0, NF, "R9 dead zero");
    shot(1'b0, 1, NF, "R9 dead one");
    shot(1'b0, F - 1, NF, "R9 dead last");
    shot(1'b1, 3, NF, "R12 slave hwy");
    wait_marker();
    n = 0;
    for (int c = 0; c < NF; c++) begin @(negedge clk); if (so) n++; end
    check_eq("R3 slave sync silent", n, 0);
    // highway mode
    mode = 2'd1;
    wait_marker();
    shot(1'b1, 3, NF + 1, "R10 stretch");
    shot(1'b1, H / 2 - 1, NF + 1, "R10 stretch edge");
    shot(1'b1, H / 2, NF - 1, "R10 shrink edge");
    shot(1'b1, 9, NF - 1, "R10 shrink");
    shot(1'b1, 1, NF, "R10 dead one");
    shot(1'b1, H - 1, NF, "R10 dead last");
    shot(1'b0, 10, NF, "R12 hwy ext");
    // R13 and R11 tracking
    mode = 2'd2;
    wait_marker();
    lock_run(NF + 1, "R13 slow ref");
    lock_run(NF - 1, "R13 fast ref");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule